// File: doc/BRIEF.md
# Periodic Tick Timer

A down-counting interval timer that sits on a small byte-wide host bus and produces a periodic interrupt request. Software programs a 24-bit reload count through four byte-wide load registers. Each register holds a 6-bit slice of the count: bits 4:0 carry the low five bits of the slice and bit 6 carries its top bit, while bit 5 is not stored. A separate control register turns the count and the interrupt request on and off independently of each other.

While counting is enabled the counter moves down by one on every clock. When it reaches zero it reloads on the following clock and sets a sticky expiry flag. The interrupt line is that flag gated by the interrupt enable. Software acknowledges an expiry by writing the control register. With the 33 MHz timebase, a reload of 165000 gives ticks about 5 ms apart and a reload of 330000 gives ticks about 10 ms apart.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, all four load registers and the control register read as 0x00 and `irq` is low.
- R2: A write to address 0..3 stores the byte into that load register with bit 5 forced to zero, and a read returns that masked byte. Address 4 is the control register: bit 0 is count enable, bit 1 is interrupt enable, and it reads back as those two bits with bits 7:2 zero.
- R3: The reload value R is {f3,f2,f1,f0}, with f0 in the least significant position. Each field fi is {byte bit 6, byte bits 4:0} of load register i. Bit 5 of a written byte has no effect on R.
- R4: When count enable changes from 0 to 1, the counter takes R on the next clock and then decrements once per clock. With interrupts enabled, `irq` rises R+2 clocks after the clock that writes the enabling value.
- R5: When the count is zero and counting is enabled, the counter reloads R on the next clock and sets the expiry flag. Expiries therefore repeat every R+1 clocks. R=0 expires on every clock.
- R6: While count enable is 0 the count holds and no expiry occurs. Setting count enable to 1 again restarts from the full value of R.
- R7: `irq` equals the expiry flag ANDed with interrupt enable. With interrupt enable at 0, `irq` stays low while the counter keeps wrapping.
- R8: Any write to the control register clears the expiry flag. If the write and an expiry fall in the same clock, the clear wins.
- R9: A write to a load register while counting does not alter the count in progress. The new R applies from the next reload.
- R10: Writes to addresses 5..7 change no register, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock; the counter steps once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are known and stable around each rising edge and that reset is applied at the start. Under those conditions the count sequence, the reload on zero and the clear priority are checked on every clock. The stimulus drives every bus input on the falling edge, holds each write for one clock only, and does not touch the bus during the windows where it measures periods. It keeps the random reload values small, so that many wraps, including R=0 and R=1 where a clear and an expiry share a clock, occur within the run.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int BUS_W     = 8;
    localparam int ADDR_W    = 3;
    localparam int LOAD_REGS = 4;
    localparam int FIELD_W   = 6;
    localparam int RELOAD_W  = LOAD_REGS * FIELD_W;

    // bits kept in a load register: 4:0 and 6
    localparam logic [BUS_W-1:0]  LOAD_MASK = 8'h5F;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(LOAD_REGS);

    typedef logic [BUS_W-1:0]    bus_byte_t;
    typedef logic [FIELD_W-1:0]  field_t;
    typedef logic [RELOAD_W-1:0] reload_t;

    // bit 1 interrupt enable, bit 0 count enable
    typedef struct packed {
        logic irq_en;
        logic cnt_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        bus_byte_t         data;
    } host_wr_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_STEP,
        ACT_WRAP
    } cnt_act_e;

    // the top bit of a slice lives in byte bit 6, bit 5 is skipped
    function automatic field_t byte_to_field(bus_byte_t b);
        return {b[6], b[4:0]};
    endfunction

    function automatic bus_byte_t ctrl_to_byte(ctrl_t c);
        return {{(BUS_W - CTRL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/tt_regs.sv
module tt_regs
    import tick_timer_pkg::*;
#(
    parameter int NREG = LOAD_REGS,
    localparam int RW  = NREG * FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  host_wr_t          bus,
    output bus_byte_t         rdata,
    output logic [RW-1:0]     reload,
    output ctrl_t             ctrl,
    output logic              ctrl_wr
);

    logic [NREG*BUS_W-1:0] load_flat;

    for (genvar g = 0; g < NREG; g++) begin : g_load
        bus_byte_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (bus.wr && bus.addr == ADDR_W'(g)) begin
                q <= bus.data & LOAD_MASK;
            end
        end

        assign load_flat[g*BUS_W +: BUS_W] = q;
        assign reload[g*FIELD_W +: FIELD_W] = byte_to_field(q);
    end

    assign ctrl_wr = bus.wr && (bus.addr == CTRL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(bus.data[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (bus.addr == ADDR_W'(i)) begin
                rdata = load_flat[i*BUS_W +: BUS_W];
            end
        end
        if (bus.addr == CTRL_ADDR) begin
            rdata = ctrl_to_byte(ctrl);
        end
    end

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tick_timer_pkg::*;
#(
    parameter int W = RELOAD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         armed,
    output logic         expire
);

    cnt_act_e act;

    always_comb begin
        if (!cnt_en) begin
            act = ACT_HOLD;
        end else if (!armed) begin
            act = ACT_LOAD;
        end else if (count == '0) begin
            act = ACT_WRAP;
        end else begin
            act = ACT_STEP;
        end
    end

    assign expire = (act == ACT_WRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
        end else begin
            armed <= cnt_en;
            case (act)
                ACT_LOAD, ACT_WRAP: count <= reload;
                ACT_STEP:           count <= count - W'(1);
                default:            count <= count;
            endcase
        end
    end

endmodule

// File: rtl/tt_flag.sv
module tt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end

    assign irq = flag & irq_en;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq
);

    host_wr_t bus;
    ctrl_t    ctrl;
    reload_t  reload;
    reload_t  count;
    logic     ctrl_wr;
    logic     cnt_en;
    logic     irq_en;
    logic     armed;
    logic     expire;
    logic     flag;

    assign bus    = '{wr: wr_en, addr: addr, data: wdata};
    assign cnt_en = ctrl.cnt_en;
    assign irq_en = ctrl.irq_en;

    tt_regs #(.NREG(LOAD_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .rdata   (rdata),
        .reload  (reload),
        .ctrl    (ctrl),
        .ctrl_wr (ctrl_wr)
    );

    tt_counter #(.W(RELOAD_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .reload (reload),
        .count  (count),
        .armed  (armed),
        .expire (expire)
    );

    tt_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (expire),
        .clr    (ctrl_wr),
        .irq_en (irq_en),
        .flag   (flag),
        .irq    (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              cnt_en,
    input logic              irq_en,
    input logic              armed,
    input reload_t           count,
    input reload_t           reload,
    input logic              flag,
    input logic              irq
);

    logic host_ctrl;
    assign host_ctrl = wr_en && (addr == CTRL_ADDR);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !flag && !armed && !irq));

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !armed) |=> (count == $past(reload)));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && armed && count != '0) |=> (count == $past(count) - RELOAD_W'(1)));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && armed && count == '0) |=> (count == $past(reload)));

    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && armed && count == '0 && !host_ctrl) |=> flag);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (flag && irq_en));

    // R8
    ctrl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        host_ctrl |=> !flag);

endmodule

bind tick_timer tick_timer_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .cnt_en (cnt_en),
    .irq_en (irq_en),
    .armed  (armed),
    .count  (count),
    .reload (reload),
    .flag   (flag),
    .irq    (irq)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;

    logic       clk   = 1'b0;
    logic       rst   = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr  = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tick_timer i_tick_timer (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    function automatic int fld(logic [7:0] b);
        return int'({b[6], b[4:0]});
    endfunction

    function automatic int reload_of(logic [7:0] r0, logic [7:0] r1,
                                     logic [7:0] r2, logic [7:0] r3);
        return fld(r0) | (fld(r1) << 6) | (fld(r2) << 12) | (fld(r3) << 18);
    endfunction

    // distance from "after" to the first expiry past it, expiries at first + k*(r+1)
    function automatic int gap_after(int first, int r, int after);
        int e = first;
        while (e <= after) e += r + 1;
        return e - after;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #2;
        d = rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n < 5000);
    endtask

    task automatic quiet(int cycles, output int seen);
        seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (irq) seen++;
        end
    endtask

    task automatic load(logic [7:0] r0, logic [7:0] r1, logic [7:0] r2, logic [7:0] r3);
        wr(3'd0, r0);
        wr(3'd1, r1);
        wr(3'd2, r2);
        wr(3'd3, r3);
    endtask

    task automatic period_test(string tag, logic [7:0] r0, logic [7:0] r1,
                               logic [7:0] r2, logic [7:0] r3);
        int r;
        int n;
        r = reload_of(r0, r1, r2, r3);
        wr(3'd4, 8'h00);
        load(r0, r1, r2, r3);
        wr(3'd4, 8'h03);
        wait_irq(n);
        check({tag, " R3/R4 first tick"}, n, r + 2);
        wr(3'd4, 8'h03);
        wait_irq(n);
        check({tag, " R5/R8 tick after clear"}, n, gap_after(0, r, 2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] shadow [4];
        int n;
        int seen;
        void'($urandom(32'h1F2E3D4C));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq after reset", int'(irq), 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reg %0d after reset", a), int'(d), 0);
        end

        // R2 readback with bit 5 masked
        for (int i = 0; i < 10; i++) begin
            logic [2:0] a;
            logic [7:0] v;
            a = 3'($urandom % 4);
            v = 8'($urandom);
            wr(a, v);
            rd(a, d);
            check($sformatf("R2 load reg %0d readback", a), int'(d), int'(v & 8'h5F));
        end
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            v = 8'($urandom) & 8'hFC;
            wr(3'd4, v | 8'(i));
            rd(3'd4, d);
            check("R2 control readback", int'(d), i);
        end

        // R3 directed: bit 6 carries the top bit of each slice, bit 5 ignored
        period_test("dir-2144", 8'h60, 8'h41, 8'h20, 8'h20);

        // R8 corner: R=0 and R=1 put an expiry on the clearing clock
        period_test("dir-r0", 8'h20, 8'h00, 8'h00, 8'h00);
        period_test("dir-r1", 8'h01, 8'h20, 8'h00, 8'h00);

        // R3/R4/R5 random small reloads
        for (int i = 0; i < 12; i++) begin
            period_test($sformatf("rnd%0d", i), 8'($urandom), 8'($urandom) & 8'h23,
                        8'($urandom) & 8'h20, 8'($urandom) & 8'h20);
        end

        // R7 gate: counting with interrupts off, then on
        wr(3'd4, 8'h00);
        load(8'h05, 8'h00, 8'h00, 8'h00);
        wr(3'd4, 8'h01);
        quiet(30, seen);
        check("R7 irq while gated", seen, 0);
        wr(3'd4, 8'h03);
        wait_irq(n);
        check("R7 irq after ungating", n, gap_after(7, 5, 32));

        // R6 halt, then restart from full reload
        wr(3'd4, 8'h00);
        load(8'h14, 8'h00, 8'h00, 8'h00);
        wr(3'd4, 8'h03);
        quiet(10, seen);
        wr(3'd4, 8'h02);
        quiet(60, seen);
        check("R6 no tick while halted", seen, 0);
        wr(3'd4, 8'h03);
        wait_irq(n);
        check("R6 restart uses full reload", n, 20 + 2);

        // R9 reload change while counting
        wr(3'd4, 8'h00);
        load(8'h0A, 8'h00, 8'h00, 8'h00);
        wr(3'd4, 8'h03);
        wr(3'd0, 8'h03);
        wait_irq(n);
        check("R9 current period keeps old reload", n, 10);
        wr(3'd4, 8'h03);
        wait_irq(n);
        check("R9 next period uses new reload", n, gap_after(0, 3, 2));

        // R10 unused addresses
        wr(3'd4, 8'h00);
        for (int a = 0; a < 4; a++) begin
            shadow[a] = 8'($urandom) & 8'h5F;
            wr(3'(a), shadow[a]);
        end
        wr(3'd4, 8'h02);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'($urandom) | 8'h03);
        end
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d);
            check($sformatf("R10 load reg %0d untouched", a), int'(d), int'(shadow[a]));
        end
        rd(3'd4, d);
        check("R10 control untouched", int'(d), 2);
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R10 read of addr %0d", a), int'(d), 0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule